// File: doc/BRIEF.md
# Console Serial Port Register File

This block is the bus-side register model of a 16550-compatible serial port, trimmed down to what an operating-system console driver needs. A processor reaches it through a byte-wide register window of eight registers. Bytes written for transmission leave on a valid/ready output stream. Bytes arriving on a valid/ready input stream are collected in a receive queue. A single level-sensitive interrupt line reports pending work.

The block has no baud-rate generator, no bit-level framing and no transmit FIFO. The divisor registers can be written and read back, but they drive nothing. A transmit write completes as soon as the output stream takes the byte. While that stream stalls, a one-byte holding register keeps the byte. A loopback mode turns transmit writes into receive queue entries, so a driver can test itself without any external traffic.

The bus is single-cycle. A request is sampled on a rising edge while `req_valid` is high. The response (`rsp_valid`, `rsp_rdata`, `rsp_err`) is registered and appears in the cycle after the request. The interrupt identification and the interrupt line are re-evaluated in the cycle after any state change.

Top module: `console_uart_regs`

## Requirements
- R1: The register index is `(req_addr >> REG_SHIFT)` truncated to 3 bits. Address bits above the index alias: with the default shift, offset 15 reaches the scratch register at index 7.
- R2: An access whose `req_size` differs from `IO_BYTES` (default 1) answers with `rsp_err`=1 and changes no register.
- R3: Reset values are as follows:
  - interrupt enable 0x00, identification 0xC1 when read, line control 0x00;
  - modem control 0x08, line status 0x60, modem status 0xB0, scratch 0x00;
  - divisor low 0x0C, divisor high 0x00.
  After reset, `irq`=0, `tx_valid`=0 and `rx_ready`=0.
- R4: A write to interrupt enable (index 1) keeps only bits 3:0. Writes to line status (index 5) and modem status (index 6) have no effect.
- R5: While line control bit 7 is set, indexes 0 and 1 access the divisor low and high bytes, and the data register and interrupt enable are left untouched.
- R6: Index 2 reads `0xC0 | code`. The code is:
  - 0x04 when enable bit 0 and data-ready (line status bit 0) are both set;
  - otherwise 0x02 when enable bit 1 and transmitter-empty (line status bit 6) are both set;
  - otherwise 0x01.
  `irq` is high exactly when the code is not 0x01.
- R7: While modem control bit 4 (loopback) is set, a write to index 0 pushes the byte into the receive queue, and `tx_valid` stays low. In loopback, `rx_ready` is low.
- R8: The receive queue holds `RXQ_DEPTH` (default 64) bytes. A push while the queue is full is dropped. `rx_ready` is high only when FIFO-control bit 0 was last written as 1, loopback is off, and the queue is not full.
- R9: A read of index 0 pops the oldest queued byte and returns it. Reading an empty queue returns 0x00. Line status bit 0 is set exactly while the queue is not empty.
- R10: Whenever interrupt enable bit 1 is clear, line status bits 6 and 5 read as 1, even while a byte is held.
- R11: Outside loopback, a write to index 0 loads a one-byte holding register, which drives `tx_valid`/`tx_data` until `tx_ready`. Bits 6:5 of line status read 0 while the byte is held (when enable bit 1 is set). A write while the holder is full is dropped.
- R12: A write to index 2 with bit 1 set empties the receive queue. A write with bit 2 set discards a held transmit byte. Neither bit is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into the register window |
| req_size | input | SIZE_W | Access width in bytes |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 8 | Read data |
| rsp_err | output | 1 | Access width rejected |
| tx_valid | output | 1 | Outgoing byte available |
| tx_ready | input | 1 | Consumer takes the outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| rx_valid | input | 1 | Incoming byte offered |
| rx_ready | output | 1 | Block accepts the incoming byte |
| rx_data | input | 8 | Incoming byte |
| irq | output | 1 | Level interrupt request |

## Verification
A corrupted queue pointer or count shows up as wrong bytes, or wrong ordering, on the next receive read. It also shows as a wrong data-ready bit in the line status, or a wrong `rx_ready` in the same cycle. A wrong holding-register state appears at once on `tx_valid` and in bits 6:5 of the line status. Interrupt state errors surface at the identification register and on `irq` one cycle after the state that caused them. Long loopback runs with a queue model catch ordering and overflow faults within a few accesses of the first divergence.

// File: rtl/console_uart_pkg.sv
package console_uart_pkg;

  typedef enum logic [2:0] {
    IDX_DATA    = 3'd0,
    IDX_IEN     = 3'd1,
    IDX_IDENT   = 3'd2,
    IDX_LINE    = 3'd3,
    IDX_MODEM   = 3'd4,
    IDX_LSTAT   = 3'd5,
    IDX_MSTAT   = 3'd6,
    IDX_SCRATCH = 3'd7
  } reg_idx_e;

  localparam logic [3:0] CODE_NONE = 4'h1;
  localparam logic [3:0] CODE_THRE = 4'h2;
  localparam logic [3:0] CODE_RXD  = 4'h4;

  localparam logic [7:0] RST_MODEM  = 8'h08;
  localparam logic [7:0] RST_DIVLO  = 8'h0C;
  localparam logic [7:0] MSTAT_FIX  = 8'hB0;
  localparam logic [7:0] IDENT_TOP  = 8'hC0;

endpackage

// File: rtl/cur_rx_queue.sv
module cur_rx_queue #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  // R8
  rxq_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R8
  rxq_full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> full);

  // R12
  rxq_flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

endmodule

// File: rtl/cur_tx_holder.sv
module cur_tx_holder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         discard,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         busy
);
  logic         full_q, full_d;
  logic [W-1:0] data_q, data_d;
  logic         data_en;

  assign data_en = load && !full_q;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (discard) begin
      full_d = 1'b0;
    end else if (full_q && out_ready) begin
      full_d = 1'b0;
    end else if (data_en) begin
      full_d = 1'b1;
      data_d = load_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      if (data_en) data_q <= data_d;
    end
  end

  assign out_valid = full_q;
  assign out_data  = data_q;
  assign busy      = full_q;

  // R11
  txh_stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !discard) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/cur_irq_eval.sv
module cur_irq_eval
  import console_uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_rx,
  input  logic       en_tx,
  input  logic       data_ready,
  input  logic       tx_empty,
  output logic [3:0] code,
  output logic       irq
);
  logic [3:0] code_q, code_d;
  logic       irq_q, irq_d;

  always_comb begin
    if (en_rx && data_ready)    code_d = CODE_RXD;
    else if (en_tx && tx_empty) code_d = CODE_THRE;
    else                        code_d = CODE_NONE;
    irq_d = (en_rx && data_ready) || (en_tx && tx_empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_NONE;
      irq_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      irq_q  <= irq_d;
    end
  end

  assign code = code_q;
  assign irq  = irq_q;

  // R6
  irq_matches_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (code != CODE_NONE));

  // R6
  irq_one_hot_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(code));

endmodule

// File: rtl/console_uart_regs.sv
module console_uart_regs
  import console_uart_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int REG_SHIFT = 0,
  parameter int SIZE_W    = 3,
  parameter int IO_BYTES  = 1,
  parameter int RXQ_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_rdata,
  output logic              rsp_err,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              irq
);
  localparam int BYTE_W = 8;

  reg_idx_e   idx;
  logic       size_ok, acc_wr, acc_rd, dlab, loop_on;
  logic       q_empty, q_full, q_push, q_pop, q_flush;
  logic [7:0] q_head, q_wdata;
  logic       lb_push, rx_take, tx_load, tx_discard, hold_busy;
  logic       thre, dready;
  logic [3:0] id_code;
  logic [7:0] lstat, rd_val;

  logic [7:0] line_q, line_d, modem_q, modem_d, scr_q, scr_d;
  logic [7:0] divlo_q, divlo_d, divhi_q, divhi_d;
  logic [3:0] ien_q, ien_d;
  logic       rxen_q, rxen_d;
  logic       rsp_valid_q, rsp_err_q;
  logic [7:0] rsp_rdata_q, rsp_rdata_d;

  // Decode
  assign idx     = reg_idx_e'(3'(req_addr >> REG_SHIFT));
  assign size_ok = (req_size == SIZE_W'(IO_BYTES));
  assign acc_wr  = req_valid && size_ok && req_write;
  assign acc_rd  = req_valid && size_ok && !req_write;
  assign dlab    = line_q[7];
  assign loop_on = modem_q[4];

  // Data path steering
  assign lb_push    = acc_wr && (idx == IDX_DATA) && !dlab && loop_on;
  assign tx_load    = acc_wr && (idx == IDX_DATA) && !dlab && !loop_on;
  assign q_flush    = acc_wr && (idx == IDX_IDENT) && req_wdata[1];
  assign tx_discard = acc_wr && (idx == IDX_IDENT) && req_wdata[2];
  assign q_pop      = acc_rd && (idx == IDX_DATA) && !dlab;
  assign rx_ready   = rxen_q && !loop_on && !q_full && !q_flush;
  assign rx_take    = rx_valid && rx_ready;
  assign q_push     = lb_push || rx_take;
  assign q_wdata    = lb_push ? req_wdata : rx_data;

  cur_rx_queue #(.DEPTH(RXQ_DEPTH), .W(BYTE_W)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_data (q_wdata),
    .pop       (q_pop),
    .flush     (q_flush),
    .head      (q_head),
    .empty     (q_empty),
    .full      (q_full)
  );

  cur_tx_holder #(.W(BYTE_W)) u_txh (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tx_load),
    .load_data (req_wdata),
    .discard   (tx_discard),
    .out_ready (tx_ready),
    .out_valid (tx_valid),
    .out_data  (tx_data),
    .busy      (hold_busy)
  );

  // Line status view
  assign dready = !q_empty;
  assign thre   = !ien_q[1] || !hold_busy;
  assign lstat  = {1'b0, thre, thre, 4'b0000, dready};

  cur_irq_eval u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_rx      (ien_q[0]),
    .en_tx      (ien_q[1]),
    .data_ready (dready),
    .tx_empty   (thre),
    .code       (id_code),
    .irq        (irq)
  );

  // Read mux
  always_comb begin
    unique case (idx)
      IDX_DATA:    rd_val = dlab ? divlo_q : (q_empty ? 8'h00 : q_head);
      IDX_IEN:     rd_val = dlab ? divhi_q : {4'b0000, ien_q};
      IDX_IDENT:   rd_val = IDENT_TOP | {4'b0000, id_code};
      IDX_LINE:    rd_val = line_q;
      IDX_MODEM:   rd_val = modem_q;
      IDX_LSTAT:   rd_val = lstat;
      IDX_MSTAT:   rd_val = MSTAT_FIX;
      IDX_SCRATCH: rd_val = scr_q;
      default:     rd_val = 8'h00;
    endcase
  end

  // Register next state
  always_comb begin
    line_d  = line_q;
    modem_d = modem_q;
    scr_d   = scr_q;
    divlo_d = divlo_q;
    divhi_d = divhi_q;
    ien_d   = ien_q;
    rxen_d  = rxen_q;
    if (acc_wr) begin
      unique case (idx)
        IDX_DATA:    if (dlab) divlo_d = req_wdata;
        IDX_IEN:     if (dlab) divhi_d = req_wdata; else ien_d = req_wdata[3:0];
        IDX_IDENT:   rxen_d  = req_wdata[0];
        IDX_LINE:    line_d  = req_wdata;
        IDX_MODEM:   modem_d = req_wdata;
        IDX_SCRATCH: scr_d   = req_wdata;
        default:     ;
      endcase
    end
    rsp_rdata_d = acc_rd ? rd_val : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q      <= 8'h00;
      modem_q     <= RST_MODEM;
      scr_q       <= 8'h00;
      divlo_q     <= RST_DIVLO;
      divhi_q     <= 8'h00;
      ien_q       <= 4'h0;
      rxen_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= 8'h00;
    end else begin
      if (acc_wr) begin
        line_q  <= line_d;
        modem_q <= modem_d;
        scr_q   <= scr_d;
        divlo_q <= divlo_d;
        divhi_q <= divhi_d;
        ien_q   <= ien_d;
        rxen_q  <= rxen_d;
      end
      rsp_valid_q <= req_valid;
      rsp_err_q   <= req_valid && !size_ok;
      rsp_rdata_q <= rsp_rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;

  // R2
  bad_width_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !size_ok) |=>
      ($stable(scr_q) && $stable(line_q) && $stable(modem_q) && $stable(ien_q)));

  // R7
  loop_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_on && !tx_valid) |=> !tx_valid);

  // R9
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && (idx == IDX_DATA) && !dlab && q_empty) |=> (rsp_rdata == 8'h00));

  // R10
  thre_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_q[1] |-> (lstat[6:5] == 2'b11));

endmodule

// File: tb/tb_console_uart_regs.sv
module tb_console_uart_regs;
  localparam int ADDR_W = 8;
  localparam int SIZE_W = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [SIZE_W-1:0] req_size;
  logic [7:0]        req_wdata;
  logic              rsp_valid, rsp_err;
  logic [7:0]        rsp_rdata;
  logic              tx_valid, tx_ready;
  logic [7:0]        tx_data;
  logic              rx_valid, rx_ready;
  logic [7:0]        rx_data;
  logic              irq;

  int nvec = 0;
  int nbad = 0;
  int tx_count = 0;
  logic [7:0] tx_last = 8'h00;

  always #5 clk = ~clk;

  console_uart_regs dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .irq(irq)
  );

  always @(posedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      tx_count <= tx_count + 1;
      tx_last  <= tx_data;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    nvec++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic access(input logic wr, input int addr, input int size,
                        input logic [7:0] data, output logic [7:0] rd,
                        output logic err);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = ADDR_W'(addr);
    req_size = SIZE_W'(size); req_wdata = data;
    @(negedge clk);
    rd = rsp_rdata; err = rsp_err;
    req_valid = 1'b0; req_write = 1'b0;
    @(negedge clk);
  endtask

  task automatic wreg(input int addr, input logic [7:0] data);
    logic [7:0] r; logic e;
    access(1'b1, addr, 1, data, r, e);
  endtask

  task automatic rreg(input int addr, output logic [7:0] d);
    logic e;
    access(1'b0, addr, 1, 8'h00, d, e);
  endtask

  task automatic expect_reg(input string tag, input int addr, input int exp);
    logic [7:0] d;
    rreg(addr, d);
    chk(tag, d, exp);
  endtask

  task automatic send_rx(input logic [7:0] b, output logic took);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    #1 took = rx_ready;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic int ident_exp(input int ien, input int qn, input int thre);
    if ((ien & 1) != 0 && qn > 0) return 8'hC4;
    if ((ien & 2) != 0 && thre != 0) return 8'hC2;
    return 8'hC1;
  endfunction

  initial begin
    #2_000_000;
    nbad++;
    $display("FAIL watchdog: got 0x1 expected 0x0");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic e, took;
    int model_q[$];
    int ien_m, base;
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = 0; req_size = 1;
    req_wdata = 0; tx_ready = 1'b1; rx_valid = 0; rx_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset state
    chk("R3 irq", irq, 0);
    chk("R3 tx_valid", tx_valid, 0);
    chk("R3 rx_ready", rx_ready, 0);
    expect_reg("R3 ien", 1, 8'h00);
    expect_reg("R3 ident", 2, 8'hC1);
    expect_reg("R3 line", 3, 8'h00);
    expect_reg("R3 modem", 4, 8'h08);
    expect_reg("R3 lstat", 5, 8'h60);
    expect_reg("R3 mstat", 6, 8'hB0);
    expect_reg("R3 scratch", 7, 8'h00);
    wreg(3, 8'h80);
    expect_reg("R3 divlo", 0, 8'h0C);
    expect_reg("R3 divhi", 1, 8'h00);

    // R5 divisor access
    wreg(0, 8'h55);
    wreg(1, 8'h12);
    expect_reg("R5 divlo", 0, 8'h55);
    expect_reg("R5 divhi", 1, 8'h12);
    wreg(3, 8'h03);
    expect_reg("R5 ien untouched", 1, 8'h00);
    expect_reg("R5 line", 3, 8'h03);
    chk("R5 no tx", tx_count, 0);

    // R2 width mismatch
    access(1'b1, 7, 2, 8'hEE, d, e);
    chk("R2 err", e, 1);
    expect_reg("R2 scratch kept", 7, 8'h00);
    access(1'b0, 7, 1, 8'h00, d, e);
    chk("R2 ok width no err", e, 0);

    // R1 index aliasing
    wreg(7, 8'hA5);
    expect_reg("R1 scratch", 7, 8'hA5);
    expect_reg("R1 alias 15", 15, 8'hA5);
    wreg(8 + 4, 8'h0B);
    expect_reg("R1 alias modem", 4, 8'h0B);

    // R4 masking and ignored writes
    wreg(1, 8'hFF);
    expect_reg("R4 ien low bits", 1, 8'h0F);
    expect_reg("R6 ident thre", 2, 8'hC2);
    chk("R6 irq thre", irq, 1);
    wreg(1, 8'h00);
    chk("R6 irq off", irq, 0);
    wreg(5, 8'h00);
    expect_reg("R4 lstat write ignored", 5, 8'h60);
    wreg(6, 8'h00);
    expect_reg("R4 mstat write ignored", 6, 8'hB0);

    // R7 / R9 loopback basics
    base = tx_count;
    wreg(4, 8'h10);
    wreg(2, 8'h01);
    chk("R7 rx_ready low in loop", rx_ready, 0);
    wreg(0, 8'h11); wreg(0, 8'h22); wreg(0, 8'h33);
    chk("R7 no tx in loop", tx_count, base);
    chk("R7 tx_valid low", tx_valid, 0);
    expect_reg("R9 data ready", 5, 8'h61);
    wreg(1, 8'h01);
    expect_reg("R6 ident rxd", 2, 8'hC4);
    chk("R6 irq rxd", irq, 1);
    wreg(1, 8'h03);
    expect_reg("R6 priority", 2, 8'hC4);
    expect_reg("R9 pop1", 0, 8'h11);
    expect_reg("R9 pop2", 0, 8'h22);
    expect_reg("R9 pop3", 0, 8'h33);
    expect_reg("R9 empty lstat", 5, 8'h60);
    expect_reg("R6 ident after drain", 2, 8'hC2);
    expect_reg("R9 empty read", 0, 8'h00);

    // R8 queue depth
    for (int i = 0; i < 70; i++) wreg(0, 8'(i + 1));
    for (int i = 0; i < 64; i++) begin
      rreg(0, d);
      if (i == 0 || i == 63) chk("R8 fill order", d, i + 1);
      else begin
        nvec++;
        if (d != 8'(i + 1)) begin
          nbad++;
          $display("FAIL R8 fill order: got 0x%0h expected 0x%0h", d, i + 1);
        end
      end
    end
    expect_reg("R8 overflow dropped", 0, 8'h00);

    // R12 receive flush
    wreg(0, 8'h44); wreg(0, 8'h55);
    wreg(2, 8'h02);
    expect_reg("R12 flush lstat", 5, 8'h60);
    expect_reg("R12 flush read", 0, 8'h00);

    // R11 / R10 transmit holding
    wreg(4, 8'h00);
    wreg(1, 8'h02);
    base = tx_count;
    wreg(0, 8'h5A);
    chk("R11 tx count", tx_count, base + 1);
    chk("R11 tx byte", tx_last, 8'h5A);
    expect_reg("R11 lstat idle", 5, 8'h60);
    tx_ready = 1'b0;
    wreg(0, 8'h3C);
    chk("R11 tx_valid held", tx_valid, 1);
    chk("R11 tx_data held", tx_data, 8'h3C);
    expect_reg("R11 lstat busy", 5, 8'h00);
    expect_reg("R6 ident none", 2, 8'hC1);
    chk("R6 irq low busy", irq, 0);
    wreg(1, 8'h00);
    expect_reg("R10 forced", 5, 8'h60);
    wreg(1, 8'h02);
    wreg(0, 8'h99);
    chk("R11 second write dropped", tx_data, 8'h3C);
    tx_ready = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R11 released count", tx_count, base + 2);
    chk("R11 released byte", tx_last, 8'h3C);
    chk("R11 valid cleared", tx_valid, 0);
    expect_reg("R11 lstat after", 5, 8'h60);
    tx_ready = 1'b0;
    wreg(0, 8'h77);
    wreg(2, 8'h04);
    chk("R12 discard held", tx_valid, 0);
    expect_reg("R12 lstat discard", 5, 8'h60);
    tx_ready = 1'b1;
    @(negedge clk);
    chk("R12 nothing sent", tx_count, base + 2);
    wreg(1, 8'h00);

    // R8 stream receive gating
    wreg(2, 8'h00);
    send_rx(8'hD1, took);
    chk("R8 rx disabled", took, 0);
    wreg(2, 8'h01);
    send_rx(8'hD2, took);
    chk("R8 rx accepted", took, 1);
    send_rx(8'hD3, took);
    expect_reg("R8 rx lstat", 5, 8'h61);
    expect_reg("R8 rx byte1", 0, 8'hD2);
    expect_reg("R8 rx byte2", 0, 8'hD3);
    wreg(4, 8'h10);
    send_rx(8'hD4, took);
    chk("R7 rx blocked in loop", took, 0);

    // Random loopback traffic against a queue model
    ien_m = 0;
    wreg(1, 8'h00);
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 4) begin
        d = 8'($urandom);
        wreg(0, d);
        if (model_q.size() < 64) model_q.push_back(d);
      end else if (op < 7) begin
        rreg(0, d);
        if (model_q.size() > 0) chk("R9 random pop", d, model_q.pop_front());
        else chk("R9 random empty", d, 0);
      end else if (op == 7) begin
        ien_m = $urandom_range(0, 15);
        wreg(1, 8'(ien_m));
      end else if (op == 8) begin
        expect_reg("R6 random ident", 2, ident_exp(ien_m, model_q.size(), 1));
        chk("R6 random irq", irq, (ident_exp(ien_m, model_q.size(), 1) != 8'hC1) ? 1 : 0);
      end else begin
        expect_reg("R9 random lstat", 5, (model_q.size() > 0) ? 8'h61 : 8'h60);
      end
    end
    chk("R7 random no tx", tx_valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule